// File: doc/BRIEF.md
# I/O Cycle Trap Capture Unit

This unit sits beside an I/O cycle decoder and compares every cycle on that path with four trap matchers. Each matcher has its own enable, a DWord address and an address mask. A cycle that hits an enabled matcher is trapped, but only while trap interrupts are globally enabled. The unit then sets that matcher's sticky status bit and raises one combined request to the power-management logic. It also records the cycle's direction, byte enables and DWord address, and, for writes, the data DWord.

The bus side holds a cycle on `cyc_valid` until the unit answers with `cyc_done`. An untrapped cycle is answered in the same clock. A trapped cycle is answered exactly one clock after its status and capture registers have been written, so the request is already up when the handler could run. Software reads the captured state through a small select-and-read port and clears status bits by writing ones.

Top module: `io_trap_capture`

## Requirements
- R1: After reset, all status bits, the cycle record and the write-data register read as zero, and `trap_req` is low.
- R2: A status bit is set only when all of the following hold: its trap is enabled, `smi_en` is high, the cycle's address bits are equal to the trap base wherever the trap mask bit is 0 (a mask bit of 1 means "ignore"), and at least one byte enable is active.
- R3: When several enabled traps match one cycle, every matching status bit is set in the same clock.
- R4: A write with `reg_sel` = 0 clears each status bit whose `reg_wdata` bit is 1. Zero bits, and writes with any other select value, change nothing. A set and a clear of the same bit in the same clock leave the bit set.
- R5: `trap_req` is high exactly when at least one status bit is set.
- R6: An untrapped cycle sees `cyc_done` in the same clock that `cyc_valid` rises. A trapped cycle sees `cyc_done` low in its first clock and high in the next clock, and the status and capture registers are already updated in that clock.
- R7: The cycle record (`reg_sel` = 1) holds these fields: bit 24 gives the direction (1 = read, 0 = write), bits 19:16 hold the byte enables, and bits 15:2 hold the DWord address. All other bits are zero. Every trapped cycle overwrites the record, even while older status bits are still pending.
- R8: The write-data register (`reg_sel` = 2) takes the 32-bit data into bits 31:0 on a trapped write and keeps its value on a trapped read. Bits 63:32 are zero.
- R9: `reg_sel` = 0 returns the status bits in bits 3:0 with all higher bits zero. `reg_sel` = 3 returns zero.
- R10: While a trapped cycle waits for its completion, the held cycle is not trapped again. A status bit cleared in that clock stays cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smi_en | input | 1 | Global enable for trap interrupts |
| trap_en | input | 4 | Per-trap enable |
| trap_base | input | 56 | Four 14-bit DWord base addresses, trap i at [14i+13:14i] |
| trap_mask | input | 56 | Four 14-bit masks, 1 = ignore that address bit |
| cyc_valid | input | 1 | I/O cycle present, held until `cyc_done` |
| cyc_read | input | 1 | 1 = read cycle, 0 = write cycle |
| cyc_addr | input | 14 | DWord address of the cycle (byte address bits 15:2) |
| cyc_be | input | 4 | Active-high byte enables |
| cyc_wdata | input | 32 | Write data DWord |
| cyc_done | output | 1 | Completion for the presented cycle |
| trap_req | output | 1 | OR of all status bits, to power management |
| reg_sel | input | 2 | Register select: 0 status, 1 cycle record, 2 write data, 3 none |
| reg_wr | input | 1 | Write strobe for the status clear |
| reg_wdata | input | 4 | Write-one-to-clear mask for the status bits |
| reg_rdata | output | 64 | Read data for the selected register |

## Verification
A wrong matcher or a wrong gate shows up as an unexpected level on `cyc_done` in the very clock the cycle is presented. It also shows up one clock later as a wrong status read and a wrong `trap_req`. A corrupt capture register can only be seen through the record and data reads, so the bench reads all three registers in the completion clock of every trapped cycle. A completion that is released early, or a held cycle that traps a second time, is exposed by the clear that the bench issues while the cycle is pending.

// File: rtl/io_trap_pkg.sv
package io_trap_pkg;
  localparam int NTRAP_D  = 4;
  localparam int ADDR_W_D = 14;
  localparam int BE_W_D   = 4;
  localparam int DATA_W_D = 32;
  localparam int REG_W    = 64;

  // record field positions read by software
  localparam int REC_ADDR_LSB = 2;
  localparam int REC_BE_LSB   = 16;
  localparam int REC_DIR_BIT  = 24;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_RECORD = 2'd1,
    SEL_WDATA  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/trap_matcher.sv
module trap_matcher #(
  parameter int ADDR_W = 14,
  parameter int BE_W   = 4
) (
  input  logic              enable,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  output logic              hit
);
  logic [ADDR_W-1:0] diff;

  always_comb begin
    diff = (addr ^ base) & ~mask;
    hit  = enable && (diff == '0) && (be != '0);
  end
endmodule

// File: rtl/trap_status.sv
module trap_status #(
  parameter int NTRAP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTRAP-1:0] set_i,
  input  logic [NTRAP-1:0] clr_i,
  output logic [NTRAP-1:0] status_o
);
  logic [NTRAP-1:0] status_q, status_d;
  logic             upd_en;

  always_comb begin
    upd_en   = (set_i != '0) || (clr_i != '0);
    status_d = (status_q & ~clr_i) | set_i;   // set wins
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status_q <= '0;
    else if (upd_en) status_q <= status_d;
  end

  assign status_o = status_q;

  // R4: a clear without a simultaneous set leaves the bit at zero
  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((status_q & $past(clr_i & ~set_i)) == '0));

  // R3: every requested set is visible in the next clock
  a_r3_all_set: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/trap_capture.sv
module trap_capture
  import io_trap_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BE_W   = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              cap_read,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [BE_W-1:0]   cap_be,
  input  logic [DATA_W-1:0] cap_wdata,
  output logic [REG_W-1:0]  rec_o,
  output logic [REG_W-1:0]  wdata_o
);
  logic              dir_q, dir_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BE_W-1:0]   be_q, be_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              data_en;

  always_comb begin
    dir_d   = cap_read;
    addr_d  = cap_addr;
    be_d    = cap_be;
    data_d  = cap_wdata;
    data_en = cap_en && !cap_read;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      addr_q <= '0;
      be_q   <= '0;
    end else if (cap_en) begin
      dir_q  <= dir_d;
      addr_q <= addr_d;
      be_q   <= be_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  always_comb begin
    rec_o = '0;
    rec_o[REC_DIR_BIT] = dir_q;
    rec_o[REC_BE_LSB +: BE_W] = be_q;
    rec_o[REC_ADDR_LSB +: ADDR_W] = addr_q;
    wdata_o = '0;
    wdata_o[DATA_W-1:0] = data_q;
  end

  // R7: the record only moves on a trapped cycle
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(rec_o));

  // R8: trapped write data lands in the data register
  a_r8_wdata: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !cap_read) |=> (wdata_o[DATA_W-1:0] == $past(cap_wdata)));

  // R8: a trapped read leaves the data register alone
  a_r8_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && cap_read) |=> $stable(wdata_o));
endmodule

// File: rtl/trap_complete.sv
module trap_complete (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_valid,
  input  logic any_hit,
  output logic accept_o,
  output logic done_o,
  output logic pend_o
);
  logic pend_q, pend_d;

  always_comb begin
    accept_o = cyc_valid && any_hit && !pend_q;
    pend_d   = accept_o;
    done_o   = pend_q || (cyc_valid && !any_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R10: a pending completion lasts one clock, and a held cycle is not accepted again
  a_r10_single_pend: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> !pend_q);

  // R6: a trapped cycle is not completed in its first clock
  a_r6_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> !done_o);
endmodule

// File: rtl/io_trap_capture.sv
module io_trap_capture
  import io_trap_pkg::*;
#(
  parameter int NTRAP  = NTRAP_D,
  parameter int ADDR_W = ADDR_W_D,
  parameter int BE_W   = BE_W_D,
  parameter int DATA_W = DATA_W_D
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smi_en,
  input  logic [NTRAP-1:0]        trap_en,
  input  logic [NTRAP*ADDR_W-1:0] trap_base,
  input  logic [NTRAP*ADDR_W-1:0] trap_mask,
  input  logic                    cyc_valid,
  input  logic                    cyc_read,
  input  logic [ADDR_W-1:0]       cyc_addr,
  input  logic [BE_W-1:0]         cyc_be,
  input  logic [DATA_W-1:0]       cyc_wdata,
  output logic                    cyc_done,
  output logic                    trap_req,
  input  logic [1:0]              reg_sel,
  input  logic                    reg_wr,
  input  logic [NTRAP-1:0]        reg_wdata,
  output logic [REG_W-1:0]        reg_rdata
);
  logic [NTRAP-1:0] hit_vec, gated_hit, set_vec, clr_vec, status;
  logic             any_hit, accept, pend;
  logic [REG_W-1:0] rec, wdata;

  for (genvar i = 0; i < NTRAP; i++) begin : g_match
    trap_matcher #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_match (
      .enable (trap_en[i]),
      .base   (trap_base[i*ADDR_W +: ADDR_W]),
      .mask   (trap_mask[i*ADDR_W +: ADDR_W]),
      .addr   (cyc_addr),
      .be     (cyc_be),
      .hit    (hit_vec[i])
    );
  end

  always_comb begin
    gated_hit = smi_en ? hit_vec : '0;
    any_hit   = (gated_hit != '0);
    set_vec   = accept ? gated_hit : '0;
    clr_vec   = (reg_wr && reg_sel == SEL_STATUS) ? reg_wdata : '0;
  end

  trap_complete u_complete (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_valid (cyc_valid),
    .any_hit   (any_hit),
    .accept_o  (accept),
    .done_o    (cyc_done),
    .pend_o    (pend)
  );

  trap_status #(.NTRAP(NTRAP)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_vec),
    .clr_i    (clr_vec),
    .status_o (status)
  );

  trap_capture #(.ADDR_W(ADDR_W), .BE_W(BE_W), .DATA_W(DATA_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (accept),
    .cap_read  (cyc_read),
    .cap_addr  (cyc_addr),
    .cap_be    (cyc_be),
    .cap_wdata (cyc_wdata),
    .rec_o     (rec),
    .wdata_o   (wdata)
  );

  assign trap_req = |status;

  always_comb begin
    unique case (reg_sel_e'(reg_sel))
      SEL_STATUS: reg_rdata = {{(REG_W-NTRAP){1'b0}}, status};
      SEL_RECORD: reg_rdata = rec;
      SEL_WDATA:  reg_rdata = wdata;
      default:    reg_rdata = '0;
    endcase
  end

  // R6: the completion of a trapped cycle comes with the request already raised
  a_r6_status_first: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (cyc_done && trap_req));

  // R2: no new status bit while trap interrupts are disabled
  a_r2_smi_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !smi_en |=> ((status & ~$past(status)) == '0));

  // R5: the request drops only when the status bits are all clear
  a_r5_req_low: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> (status == '0));
endmodule

// File: tb/io_trap_capture_bench.sv
`timescale 1ns/1ps
module io_trap_capture_bench;
  localparam int N = 4, AW = 14, BW = 4, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smi_en;
  logic [N-1:0] trap_en;
  logic [N*AW-1:0] trap_base, trap_mask;
  logic cyc_valid, cyc_read, cyc_done, trap_req;
  logic [AW-1:0] cyc_addr;
  logic [BW-1:0] cyc_be;
  logic [DW-1:0] cyc_wdata;
  logic [1:0] reg_sel;
  logic reg_wr;
  logic [N-1:0] reg_wdata;
  logic [63:0] reg_rdata;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [N-1:0] m_status;
  logic [63:0] m_rec, m_wdata;

  always #5 clk = ~clk;

  io_trap_capture u_io_trap_capture (.*);

  function automatic logic [N-1:0] exp_hits(logic [AW-1:0] a, logic [BW-1:0] be);
    logic [N-1:0] h = '0;
    for (int i = 0; i < N; i++)
      if (smi_en && trap_en[i] && be != 0 &&
          ((a ^ trap_base[i*AW +: AW]) & ~trap_mask[i*AW +: AW]) == 0) h[i] = 1'b1;
    return h;
  endfunction

  function automatic logic [63:0] exp_rec(logic rd, logic [BW-1:0] be, logic [AW-1:0] a);
    return {39'b0, rd, 4'b0, be, a, 2'b0};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(logic [1:0] sel, logic [63:0] exp, string tag);
    reg_sel = sel;
    #0.5;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic check_all(string tag);
    rd_chk(2'd0, {60'b0, m_status}, {tag, " R9 status"});
    chk({tag, " R5 trap_req"}, trap_req, |m_status);
    rd_chk(2'd1, m_rec, {tag, " R7 record"});
    rd_chk(2'd2, m_wdata, {tag, " R8 wdata"});
  endtask

  // one bus cycle; clr_same clears during the first clock, clr_pend during completion
  task automatic run_cycle(logic [AW-1:0] a, logic [BW-1:0] be, logic rd,
                           logic [DW-1:0] d, logic [N-1:0] clr_same, logic [N-1:0] clr_pend);
    logic [N-1:0] h;
    @(negedge clk);
    cyc_valid = 1; cyc_addr = a; cyc_be = be; cyc_read = rd; cyc_wdata = d;
    reg_sel = 2'd0; reg_wr = (clr_same != 0); reg_wdata = clr_same;
    h = exp_hits(a, be);
    #0.5;
    chk("R6 done in first clock", cyc_done, h == 0);
    @(posedge clk); #0.5;
    reg_wr = 0;
    m_status = (m_status & ~clr_same) | h;
    if (h != 0) begin
      m_rec = exp_rec(rd, be, a);
      if (!rd) m_wdata = {32'b0, d};
      @(negedge clk); #0.5;
      chk("R6 done after trap", cyc_done, 1'b1);
      check_all("R2/R3 trapped");
      reg_sel = 2'd0; reg_wr = (clr_pend != 0); reg_wdata = clr_pend;
      @(posedge clk); #0.5;
      reg_wr = 0;
      m_status = m_status & ~clr_pend;
    end
    @(negedge clk);
    cyc_valid = 0;
    #0.5;
    rd_chk(2'd0, {60'b0, m_status}, "R10/R4 status after cycle");
  endtask

  task automatic sw_write(logic [1:0] sel, logic [N-1:0] v);
    @(negedge clk);
    reg_sel = sel; reg_wr = 1; reg_wdata = v;
    @(posedge clk); #0.5;
    reg_wr = 0;
    if (sel == 2'd0) m_status = m_status & ~v;
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    smi_en = 1; cyc_valid = 0; cyc_read = 0; cyc_addr = 0; cyc_be = 0; cyc_wdata = 0;
    reg_sel = 0; reg_wr = 0; reg_wdata = 0;
    trap_en = 4'b0111;
    trap_base = '0; trap_mask = '0;
    trap_base[0*AW +: AW] = 14'h0100; trap_mask[0*AW +: AW] = 14'h0000;
    trap_base[1*AW +: AW] = 14'h0100; trap_mask[1*AW +: AW] = 14'h0007;
    trap_base[2*AW +: AW] = 14'h0200; trap_mask[2*AW +: AW] = 14'h0003;
    trap_base[3*AW +: AW] = 14'h0300; trap_mask[3*AW +: AW] = 14'h0000;
    m_status = 0; m_rec = 0; m_wdata = 0;
    repeat (3) @(posedge clk);
    #0.5;
    check_all("R1 reset");
    rd_chk(2'd3, 64'd0, "R9 unused select");
    @(negedge clk); rst_n = 1;

    // R3: base 0x100 hits traps 0 and 1 together
    run_cycle(14'h0100, 4'b0011, 1'b0, 32'hCAFE_F00D, 0, 0);
    // R7: read overwrites the record while status is still pending; R8 data kept
    run_cycle(14'h0201, 4'b1000, 1'b1, 32'h1111_2222, 0, 0);
    // R2: no byte enables, no trap
    run_cycle(14'h0100, 4'b0000, 1'b0, 32'h0, 0, 0);
    // R2: disabled trap 3 does not fire
    run_cycle(14'h0300, 4'b1111, 1'b0, 32'h5, 0, 0);
    // R4: writes to other selects and zero bits are ignored
    sw_write(2'd1, 4'hF); sw_write(2'd2, 4'hF); sw_write(2'd0, 4'h0);
    #0.5; rd_chk(2'd0, {60'b0, m_status}, "R4 ignored writes");
    sw_write(2'd0, 4'b0001);
    #0.5; rd_chk(2'd0, {60'b0, m_status}, "R4 single clear");
    // R4: set wins over a clear in the same clock
    run_cycle(14'h0104, 4'b0100, 1'b0, 32'hABCD_0123, 4'b0010, 0);
    // R10: clear during completion stays cleared, held cycle not retrapped
    run_cycle(14'h0100, 4'b1111, 1'b0, 32'h7777_8888, 0, 4'b1111);
    // R2: global enable off
    smi_en = 0;
    run_cycle(14'h0100, 4'b1111, 1'b0, 32'h9, 0, 0);
    smi_en = 1;

    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] a;
      logic [N-1:0] cs, cp;
      case ($urandom % 4)
        0: a = 14'h0100 | 14'($urandom % 8);
        1: a = 14'h0200 | 14'($urandom % 8);
        2: a = 14'h0300;
        default: a = 14'($urandom);
      endcase
      cs = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      cp = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      smi_en = ($urandom % 8 != 0);
      run_cycle(a, 4'($urandom), 1'($urandom), $urandom, cs, cp);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule